// File: doc/BRIEF.md
# Clocked Bus Read Master

This block is the requester side of a clocked parallel bus. It handles single-word reads only. A local client pulses `start` with an address. The block then walks the bus through a fixed sequence. First it drives the address. On the following rising edge it raises the read request. On falling edges it watches the target's wait line, and it captures the data bus at the first falling edge where wait is low.

Once the word is captured, the block drops the request and the address at the next rising edge. It does not wait for any reply from the target. In that same cycle it shows the word on `rdData` with a one-cycle `done` pulse. Because the bus is idle again by then, a new read can be accepted right away. A target that needs more time keeps its wait line high, and the block tries again on every falling edge, with no limit on the number of retries.

Top module: `sync_read_master`

## Requirements
- R1: In the cycle after the rising edge that accepts `start`, `busAddrEn` is 1, `busAddr` equals the requested address and `busRead` is still 0.
- R2: `busRead` rises exactly one rising edge after the address is first driven, and `busAddr` holds its value for as long as `busRead` is 1.
- R3: The block samples `busWait` only on falling edges while `busRead` is 1. If `busWait` is high at N such falling edges in a row, `done` is 1 in the cycle that starts N+2 rising edges after the accepting edge.
- R4: `rdData` equals the value `busData` carried at the first falling edge where `busWait` was low. Values present on `busData` while `busWait` is high are never captured.
- R5: `done` is high for exactly one cycle. `rdData` holds the captured word after `done` falls.
- R6: In the cycle where `done` is 1, `busRead` is 0, `busAddrEn` is 0 and `busAddr` is all zeros, which is its idle level.
- R7: A `start` pulse during a transfer is ignored. The address on the bus does not change, and no second transfer follows the current one.
- R8: A `start` pulse given during the `done` cycle is accepted, and the next transfer follows at once.
- R9: While `rstN` is low, and right after it is released, `busRead`, `busAddrEn`, `busAddr` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. Bus steps happen on rising edges; data and wait are sampled on falling edges |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a read; taken only when the block is idle |
| reqAddr | input | ADDR_W | Address to read, sampled together with `start` |
| rdData | output | DATA_W | Last word captured from the bus |
| done | output | 1 | One-cycle pulse when `rdData` holds a new word |
| busAddr | output | ADDR_W | Address driven onto the bus; zero when idle |
| busAddrEn | output | 1 | High while the address is being driven |
| busRead | output | 1 | Read request to the target |
| busData | input | DATA_W | Data bus from the target |
| busWait | input | 1 | Target stall; high means the data is not ready yet |

## Verification
If the sequencer lands in a wrong state, the bus pins show it within one rising edge. Examples are an early or missing `busRead`, an address that moves mid-transfer, or request lines left high in the `done` cycle. Each of these is checked in the cycle it occurs. A fault in the falling-edge sampler does not show until the `done` cycle. There it appears as a latency that differs from N+2 for N wait edges, or as `rdData` holding the filler value the target drives while stalling. The bench therefore changes the wait count and keeps that filler value distinct from the real data.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_REQ  = 2'd2
  } srmState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAddr;   // latch reqAddr this edge
    logic driveAddr;  // address phase active
    logic driveRead;  // read request active
    logic commit;     // word captured, finish this edge
  } srmCtl_t;

endpackage

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    gotData,
  output srmCtl_t ctl
);

  srmState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (start) stateNxt = ST_ADDR;
      ST_ADDR: stateNxt = ST_REQ;
      ST_REQ:  if (gotData) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl.loadAddr  = (state == ST_IDLE) && start;
    ctl.driveAddr = (state == ST_ADDR) || (state == ST_REQ);
    ctl.driveRead = (state == ST_REQ);
    ctl.commit    = (state == ST_REQ) && gotData;
  end

endmodule

// File: rtl/srm_datapath.sv
module srm_datapath
  import srm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  srmCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWait,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrEn,
  output logic              busRead,
  output logic              gotData,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ADDR_IDLE = '0;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrReg <= '0;
    else if (ctl.loadAddr) addrReg <= reqAddr;
  end

  assign busAddr   = ctl.driveAddr ? addrReg : ADDR_IDLE;
  assign busAddrEn = ctl.driveAddr;
  assign busRead   = ctl.driveRead;

  // falling-edge sampler: capture only when the target is not stalling
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      gotData <= 1'b0;
      dataCap <= '0;
    end else if (ctl.driveRead && !busWait) begin
      gotData <= 1'b1;
      dataCap <= busData;
    end else begin
      gotData <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done   <= 1'b0;
      rdData <= '0;
    end else begin
      done <= ctl.commit;
      if (ctl.commit) rdData <= dataCap;
    end
  end

endmodule

// File: rtl/sync_read_master.sv
module sync_read_master
  import srm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrEn,
  output logic              busRead,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWait
);

  srmCtl_t ctl;
  logic    gotData;

  srm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .gotData (gotData),
    .ctl     (ctl)
  );

  srm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .busData   (busData),
    .busWait   (busWait),
    .busAddr   (busAddr),
    .busAddrEn (busAddrEn),
    .busRead   (busRead),
    .gotData   (gotData),
    .rdData    (rdData),
    .done      (done)
  );

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAddrEn,
  input logic              busRead,
  input logic              done
);

  a_r2_addr_before_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRead) |-> $past(busAddrEn));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> (busAddrEn && $stable(busAddr)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_released_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busRead && !busAddrEn && busAddr == '0));

  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrEn && $past(busAddrEn)) |-> $stable(busAddr));

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !busAddrEn |-> (busAddr == '0 && !busRead));

endmodule

bind sync_read_master srm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busAddrEn (busAddrEn),
  .busRead   (busRead),
  .done      (done)
);

// File: tb/tb_sync_read_master.sv
module tb_sync_read_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  rdData;
  logic        done;
  logic [15:0] busAddr;
  logic        busAddrEn;
  logic        busRead;
  logic [7:0]  busData = 8'h5A;
  logic        busWait = 1'b0;

  int vectors = 0;
  int misses  = 0;
  int waitLeft = 0;
  logic [7:0] memVal = '0;

  sync_read_master dut (
    .clk(clk), .rstN(rstN), .start(start), .reqAddr(reqAddr),
    .rdData(rdData), .done(done), .busAddr(busAddr), .busAddrEn(busAddrEn),
    .busRead(busRead), .busData(busData), .busWait(busWait)
  );

  always #5 clk = ~clk;

  // target model: stalls waitLeft cycles, drives filler while stalling
  always @(posedge clk) begin
    #2;
    if (busRead) begin
      if (waitLeft > 0) begin
        busWait = 1'b1;
        busData = ~memVal;
        waitLeft--;
      end else begin
        busWait = 1'b0;
        busData = memVal;
      end
    end else begin
      busWait = 1'b0;
      busData = 8'h5A;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(!busRead, req, busRead, 0);
    check(!busAddrEn, req, busAddrEn, 0);
    check(busAddr == 16'h0, req, busAddr, 0);
    check(!done, req, done, 0);
  endtask

  // one read; called at a falling edge
  task automatic doRead(input logic [15:0] a, input int waits, input logic [7:0] val,
                        input bit midStart, input bit chain);
    int k;
    waitLeft = waits;
    memVal   = val;
    reqAddr  = a;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busAddrEn && busAddr == a, "R1 addr driven", busAddr, a);
    check(!busRead, "R1 read low in addr phase", busRead, 0);
    @(negedge clk);
    check(busRead && busAddr == a, "R2 read raised", {busRead, busAddr}, {1'b1, a});
    if (midStart) begin
      start   = 1'b1;
      reqAddr = ~a;
    end
    k = 2;
    while (!done && k < 60) begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (busRead) check(busAddr == a, "R7 addr unchanged", busAddr, a);
    end
    check(done && k == waits + 3, "R3 latency", k, waits + 3);
    check(rdData == val, "R4 captured word", rdData, val);
    check(!busRead && !busAddrEn && busAddr == 16'h0, "R6 released at done",
          {busRead, busAddrEn, busAddr}, 0);
    if (!chain) begin
      @(negedge clk);
      check(!done, "R5 single pulse", done, 0);
      check(rdData == val, "R5 data held", rdData, val);
      check(!busAddrEn, "R7 no second transfer", busAddrEn, 0);
      @(negedge clk);
      checkIdle("R7 still idle");
    end
  endtask

  task automatic testReset();
    #1;
    checkIdle("R9 in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R9 after reset");
  endtask

  task automatic testResetMid();
    waitLeft = 10;
    memVal   = 8'hEE;
    reqAddr  = 16'h0BAD;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkIdle("R9 reset mid transfer");
    @(negedge clk);
    rstN = 1'b1;
    waitLeft = 0;
    repeat (2) @(negedge clk);
    checkIdle("R9 idle after mid reset");
  endtask

  initial begin
    testReset();
    doRead(16'h1234, 0, 8'hA5, 1'b0, 1'b0);
    doRead(16'hBEEF, 1, 8'h3C, 1'b0, 1'b0);
    doRead(16'h00F0, 4, 8'h81, 1'b0, 1'b0);
    doRead(16'hC001, 3, 8'h66, 1'b1, 1'b0);
    doRead(16'hFFFF, 0, 8'h00, 1'b0, 1'b1);  // R8 chain start in done cycle
    doRead(16'h7E57, 2, 8'hFF, 1'b0, 1'b1);
    doRead(16'h0001, 0, 8'h12, 1'b0, 1'b0);
    testResetMid();
    doRead(16'h4242, 5, 8'h99, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule